// File: doc/BRIEF.md
# Staged NCO Frequency Register Bank

This block holds the tuning settings for four numerically controlled oscillators and feeds them to the oscillator datapath. A byte-wide write port with a 14-bit address reaches a 64-bit frequency word and a 16-bit phase word for each oscillator, plus a mask that selects which oscillators have their phase accumulator cleared on a sync event. A second, shorter 32-bit view of each frequency word writes the upper half of the same storage, so that a coarse retune needs only four bytes.

Writes land in staging registers and do not move the outputs. When `sync_evt` is high for one cycle, every staged frequency and phase value is copied into the active registers at that clock edge. In the same edge, a one-cycle clear pulse is registered for each oscillator whose mask bit is set. The `fast_sel` input chooses what the datapath sees. When it is high, the active registers drive the outputs. When it is low, the normal frequency and phase inputs pass straight through and no clear pulses are produced.

Top module: `nco_stage_bank`

## Requirements
- R1: After reset, all staged and active frequency and phase words are zero, the clear mask is 4'b1111, and `acc_clr` is zero.
- R2: A write to address 0x0100 + 8*n + k sets byte k of oscillator n's 64-bit frequency word, where byte 0 is bits [7:0].
- R3: A write to address 0x0120 + 2*n + k sets byte k of oscillator n's 16-bit phase word, where byte 0 is bits [7:0].
- R4: A write to address 0x0128 + 4*n + k sets byte 4+k of oscillator n's frequency word. The lower 32 bits of that word are left unchanged.
- R5: The 32-bit view and the upper half of the 64-bit word share one storage. The most recent write to a byte wins, whichever view it came through.
- R6: Writes without a sync event leave `freq_out` and `phase_out` unchanged.
- R7: At the clock edge where `sync_evt` is high, all staged words are copied to the active registers. From the next cycle on, the outputs show them. The transfer happens whatever the level of `fast_sel`.
- R8: A write to address 0x00FF loads data bits [3:0] into the clear mask and ignores bits [7:4]. In the cycle after a sync edge with `fast_sel` high, `acc_clr` equals the mask for exactly one cycle.
- R9: While `fast_sel` is low, `freq_out` equals `norm_freq`, `phase_out` equals `norm_phase`, and `acc_clr` stays zero.
- R10: Writes to any address outside 0x00FF and 0x0100–0x0137 change no stored value.
- R11: A write in the same cycle as `sync_evt` is staged but is not part of that transfer. It appears at the next sync.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Byte write strobe |
| wr_addr | input | 14 | Byte address |
| wr_data | input | 8 | Byte to write |
| sync_evt | input | 1 | One-cycle sync event |
| fast_sel | input | 1 | Select the staged bank (1) or the normal inputs (0) |
| norm_freq | input | 256 | Normal frequency words, oscillator n at bits [64n+63:64n] |
| norm_phase | input | 64 | Normal phase words, oscillator n at bits [16n+15:16n] |
| freq_out | output | 256 | Frequency words sent to the oscillators |
| phase_out | output | 64 | Phase words sent to the oscillators |
| acc_clr | output | 4 | One-cycle accumulator clear, one bit per oscillator |

## Verification
The bench fills frequency words with distinct byte patterns through the 64-bit view. It then overwrites only the upper bytes through the 32-bit view and checks that the lower half survives, which separates correct aliasing from a full-word overwrite. It then writes one byte through the 64-bit view to show that the shared storage takes the latest write. Writes without a sync, writes to unmapped and neighbouring addresses, and a write in the same cycle as a sync each show whether staging and decode have the right boundaries. Mask patterns with the upper nibble set, and syncs with `fast_sel` low, separate the clear-pulse gating from the bypass path.

// File: rtl/nco_bank_pkg.sv
// Package: shared sizes and the address map anchors of the NCO register bank.
// Assumes byte-wide writes; all other addresses are derived from these.
package nco_bank_pkg;
    localparam int N_OSC      = 4;
    localparam int FREQ_W     = 64;
    localparam int PHASE_W    = 16;
    localparam int ADDR_W     = 14;
    localparam int DATA_W     = 8;
    localparam int MASK_ADDR  = 'h00FF;
    localparam int FREQ_BASE  = 'h0100;
endpackage

// File: rtl/nco_addr_decode.sv
// Module: nco_addr_decode
// Turns a byte write into one-hot byte enables for the frequency and phase
// storage, and into the mask write enable. The 32-bit short view is folded
// onto the upper bytes of each frequency word here. Assumes the phase block
// directly follows the frequency block and the short block follows phase.
module nco_addr_decode #(
    parameter int N_OSC     = 4,
    parameter int FREQ_B    = 8,
    parameter int PHASE_B   = 2,
    parameter int ADDR_W    = 14,
    parameter int MASK_ADDR = 'h00FF,
    parameter int FREQ_BASE = 'h0100
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [ADDR_W-1:0]         wr_addr,
    output logic [N_OSC*FREQ_B-1:0]   freq_be,
    output logic [N_OSC*PHASE_B-1:0]  phase_be,
    output logic                      mask_we
);
    localparam int SHORT_B    = FREQ_B / 2;
    localparam int PHASE_BASE = FREQ_BASE + N_OSC * FREQ_B;
    localparam int SHORT_BASE = PHASE_BASE + N_OSC * PHASE_B;

    // Mask register hit.
    assign mask_we = wr_en && (wr_addr == ADDR_W'(MASK_ADDR));

    // Frequency byte enables: long view everywhere, short view on upper bytes.
    for (genvar i = 0; i < N_OSC * FREQ_B; i++) begin : g_fbe
        localparam int OSC = i / FREQ_B;
        localparam int BYT = i % FREQ_B;
        if (BYT >= SHORT_B) begin : g_alias
            assign freq_be[i] = wr_en &&
                ((wr_addr == ADDR_W'(FREQ_BASE + i)) ||
                 (wr_addr == ADDR_W'(SHORT_BASE + OSC * SHORT_B + BYT - SHORT_B)));
        end else begin : g_plain
            assign freq_be[i] = wr_en && (wr_addr == ADDR_W'(FREQ_BASE + i));
        end
    end

    // Phase byte enables.
    for (genvar j = 0; j < N_OSC * PHASE_B; j++) begin : g_pbe
        assign phase_be[j] = wr_en && (wr_addr == ADDR_W'(PHASE_BASE + j));
    end

    // R10: a write reaches at most one storage byte.
    a_r10_single_target: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({freq_be, phase_be, mask_we}));

    // R10: no strobe, no enable.
    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |-> ({freq_be, phase_be, mask_we} == '0));
endmodule

// File: rtl/nco_stage_regs.sv
// Module: nco_stage_regs
// Staging storage: byte-written frequency and phase words plus the clear
// mask. Assumes the enables are already one-hot per write.
module nco_stage_regs #(
    parameter int N_OSC   = 4,
    parameter int FREQ_W  = 64,
    parameter int PHASE_W = 16,
    parameter int DATA_W  = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [N_OSC*FREQ_W/DATA_W-1:0]  freq_be,
    input  logic [N_OSC*PHASE_W/DATA_W-1:0] phase_be,
    input  logic                        mask_we,
    input  logic [DATA_W-1:0]           wr_data,
    output logic [N_OSC*FREQ_W-1:0]     stg_freq,
    output logic [N_OSC*PHASE_W-1:0]    stg_phase,
    output logic [N_OSC-1:0]            clr_mask
);
    localparam int NF = N_OSC * FREQ_W / DATA_W;
    localparam int NP = N_OSC * PHASE_W / DATA_W;

    // Frequency staging bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg_freq <= '0;
        end else begin
            for (int i = 0; i < NF; i++) begin
                if (freq_be[i]) stg_freq[i*DATA_W +: DATA_W] <= wr_data;
            end
        end
    end

    // Phase staging bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg_phase <= '0;
        end else begin
            for (int j = 0; j < NP; j++) begin
                if (phase_be[j]) stg_phase[j*DATA_W +: DATA_W] <= wr_data;
            end
        end
    end

    // Clear mask: low bits only, all set after reset.
    always_ff @(posedge clk) begin
        if (!rst_n)       clr_mask <= '1;
        else if (mask_we) clr_mask <= wr_data[N_OSC-1:0];
    end

    // R10: without enables the staged state holds.
    a_r10_stage_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ({freq_be, phase_be, mask_we} == '0) |=>
            ($stable(stg_freq) && $stable(stg_phase) && $stable(clr_mask)));
endmodule

// File: rtl/nco_active_regs.sv
// Module: nco_active_regs
// Active registers loaded from staging on a sync event, plus the registered
// per-oscillator clear pulse. Assumes sync_evt is a single-cycle strobe.
module nco_active_regs #(
    parameter int N_OSC   = 4,
    parameter int FREQ_W  = 64,
    parameter int PHASE_W = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      sync_evt,
    input  logic                      fast_sel,
    input  logic [N_OSC*FREQ_W-1:0]   stg_freq,
    input  logic [N_OSC*PHASE_W-1:0]  stg_phase,
    input  logic [N_OSC-1:0]          clr_mask,
    output logic [N_OSC*FREQ_W-1:0]   act_freq,
    output logic [N_OSC*PHASE_W-1:0]  act_phase,
    output logic [N_OSC-1:0]          acc_clr
);
    // Transfer staged words on sync.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_freq  <= '0;
            act_phase <= '0;
        end else if (sync_evt) begin
            act_freq  <= stg_freq;
            act_phase <= stg_phase;
        end
    end

    // One-cycle clear pulse for masked oscillators when the bank is selected.
    always_ff @(posedge clk) begin
        if (!rst_n) acc_clr <= '0;
        else        acc_clr <= (sync_evt && fast_sel) ? clr_mask : '0;
    end

    // R7: sync copies staging into the active registers.
    a_r7_transfer: assert property (@(posedge clk) disable iff (!rst_n)
        sync_evt |=> (act_freq == $past(stg_freq)) && (act_phase == $past(stg_phase)));

    // R6: no sync, no change of active words.
    a_r6_active_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_evt |=> ($stable(act_freq) && $stable(act_phase)));

    // R8: clear pulses only follow a sync.
    a_r8_pulse_after_sync: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_evt |=> (acc_clr == '0));

    // R9: no clear pulses while the bank is bypassed.
    a_r9_no_clr_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        !fast_sel |=> (acc_clr == '0));
endmodule

// File: rtl/nco_stage_bank.sv
// Module: nco_stage_bank (top)
// Byte-addressed staged register bank for N_OSC oscillators with a sync
// transfer and a bypass to normal frequency/phase inputs. Assumes a
// synchronous active-low reset and a single-cycle sync strobe.
module nco_stage_bank
    import nco_bank_pkg::*;
#(
    parameter int N_OSC   = nco_bank_pkg::N_OSC,
    parameter int FREQ_W  = nco_bank_pkg::FREQ_W,
    parameter int PHASE_W = nco_bank_pkg::PHASE_W,
    parameter int ADDR_W  = nco_bank_pkg::ADDR_W,
    parameter int DATA_W  = nco_bank_pkg::DATA_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [ADDR_W-1:0]         wr_addr,
    input  logic [DATA_W-1:0]         wr_data,
    input  logic                      sync_evt,
    input  logic                      fast_sel,
    input  logic [N_OSC*FREQ_W-1:0]   norm_freq,
    input  logic [N_OSC*PHASE_W-1:0]  norm_phase,
    output logic [N_OSC*FREQ_W-1:0]   freq_out,
    output logic [N_OSC*PHASE_W-1:0]  phase_out,
    output logic [N_OSC-1:0]          acc_clr
);
    localparam int FREQ_B  = FREQ_W / DATA_W;
    localparam int PHASE_B = PHASE_W / DATA_W;

    logic [N_OSC*FREQ_B-1:0]  freq_be;
    logic [N_OSC*PHASE_B-1:0] phase_be;
    logic                     mask_we;
    logic [N_OSC*FREQ_W-1:0]  stg_freq, act_freq;
    logic [N_OSC*PHASE_W-1:0] stg_phase, act_phase;
    logic [N_OSC-1:0]         clr_mask;

    nco_addr_decode #(
        .N_OSC(N_OSC), .FREQ_B(FREQ_B), .PHASE_B(PHASE_B), .ADDR_W(ADDR_W),
        .MASK_ADDR(MASK_ADDR), .FREQ_BASE(FREQ_BASE)
    ) u_dec (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .freq_be(freq_be), .phase_be(phase_be), .mask_we(mask_we)
    );

    nco_stage_regs #(
        .N_OSC(N_OSC), .FREQ_W(FREQ_W), .PHASE_W(PHASE_W), .DATA_W(DATA_W)
    ) u_stage (
        .clk(clk), .rst_n(rst_n), .freq_be(freq_be), .phase_be(phase_be),
        .mask_we(mask_we), .wr_data(wr_data), .stg_freq(stg_freq),
        .stg_phase(stg_phase), .clr_mask(clr_mask)
    );

    nco_active_regs #(
        .N_OSC(N_OSC), .FREQ_W(FREQ_W), .PHASE_W(PHASE_W)
    ) u_active (
        .clk(clk), .rst_n(rst_n), .sync_evt(sync_evt), .fast_sel(fast_sel),
        .stg_freq(stg_freq), .stg_phase(stg_phase), .clr_mask(clr_mask),
        .act_freq(act_freq), .act_phase(act_phase), .acc_clr(acc_clr)
    );

    // Output select between the active bank and the normal inputs.
    assign freq_out  = fast_sel ? act_freq  : norm_freq;
    assign phase_out = fast_sel ? act_phase : norm_phase;
endmodule

// File: tb/tb_nco_stage_bank.sv
// Scoreboard bench: driver tasks keep a model of the bank and push expected
// outputs into a queue; a monitor pops and compares on falling edges.
module tb_nco_stage_bank;
    localparam int CLK_P = 10;

    logic         clk = 0;
    logic         rst_n = 0;
    logic         wr_en = 0;
    logic [13:0]  wr_addr = '0;
    logic [7:0]   wr_data = '0;
    logic         sync_evt = 0;
    logic         fast_sel = 1;
    logic [255:0] norm_freq = {4{64'hDEAD_BEEF_0BAD_F00D}};
    logic [63:0]  norm_phase = 64'h1357_2468_9ABC_DEF0;
    logic [255:0] freq_out;
    logic [63:0]  phase_out;
    logic [3:0]   acc_clr;

    nco_stage_bank dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .sync_evt(sync_evt), .fast_sel(fast_sel),
        .norm_freq(norm_freq), .norm_phase(norm_phase),
        .freq_out(freq_out), .phase_out(phase_out), .acc_clr(acc_clr)
    );

    always #(CLK_P/2) clk = ~clk;

    typedef struct {
        string        tag;
        logic [255:0] f;
        logic [63:0]  p;
        logic [3:0]   c;
    } exp_t;

    exp_t sb[$];
    int   checks = 0;
    int   errors = 0;
    bit   done = 0;

    // Bench model of the bank.
    logic [63:0] m_sf[4], m_af[4];
    logic [15:0] m_sp[4], m_ap[4];
    logic [3:0]  m_mask;

    function automatic void model_reset();
        for (int i = 0; i < 4; i++) begin
            m_sf[i] = '0; m_af[i] = '0; m_sp[i] = '0; m_ap[i] = '0;
        end
        m_mask = 4'hF;
    endfunction

    function automatic void model_write(int a, logic [7:0] d);
        if (a == 'h00FF) m_mask = d[3:0];
        else if (a >= 'h0100 && a < 'h0120) m_sf[(a-'h100)/8][((a-'h100)%8)*8 +: 8] = d;
        else if (a >= 'h0120 && a < 'h0128) m_sp[(a-'h120)/2][((a-'h120)%2)*8 +: 8] = d;
        else if (a >= 'h0128 && a < 'h0138) m_sf[(a-'h128)/4][(4+(a-'h128)%4)*8 +: 8] = d;
    endfunction

    function automatic void push_exp(string tag, logic [3:0] c);
        exp_t e;
        e.tag = tag;
        for (int i = 0; i < 4; i++) begin
            e.f[i*64 +: 64] = m_af[i];
            e.p[i*16 +: 16] = m_ap[i];
        end
        if (!fast_sel) begin
            e.f = norm_freq;
            e.p = norm_phase;
        end
        e.c = c;
        sb.push_back(e);
    endfunction

    // Monitor: compare one expected item per falling edge.
    initial begin
        forever begin
            @(negedge clk);
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                checks++;
                if (freq_out !== e.f || phase_out !== e.p || acc_clr !== e.c) begin
                    errors++;
                    $display("FAIL %s: actual f=%h p=%h c=%h expected f=%h p=%h c=%h",
                             e.tag, freq_out, phase_out, acc_clr, e.f, e.p, e.c);
                end
            end
        end
    end

    task automatic wr(int a, logic [7:0] d);
        @(negedge clk);
        wr_en = 1; wr_addr = 14'(a); wr_data = d;
        @(posedge clk); #1;
        wr_en = 0;
        model_write(a, d);
    endtask

    task automatic expect_now(string tag);
        push_exp(tag, 4'h0);
        @(negedge clk); #1;
    endtask

    // Sync, optionally with a write in the same cycle; checks pulse and after.
    task automatic do_sync(string tag, bit with_wr, int a, logic [7:0] d);
        @(negedge clk);
        sync_evt = 1;
        if (with_wr) begin wr_en = 1; wr_addr = 14'(a); wr_data = d; end
        @(posedge clk); #1;
        sync_evt = 0; wr_en = 0;
        for (int i = 0; i < 4; i++) begin m_af[i] = m_sf[i]; m_ap[i] = m_sp[i]; end
        if (with_wr) model_write(a, d);
        push_exp({tag, " pulse"}, fast_sel ? m_mask : 4'h0);
        @(negedge clk); #1;
        push_exp({tag, " after"}, 4'h0);
        @(negedge clk); #1;
    endtask

    // Watchdog.
    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=timeout expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        expect_now("R1 reset outputs zero");
        do_sync("R1 default mask all set R8", 0, 0, 0);

        // R2: long frequency bytes, distinct per byte.
        for (int b = 0; b < 8; b++) wr('h0100 + b, 8'(8'h10 + b));
        for (int b = 0; b < 8; b++) wr('h0118 + b, 8'(8'hA0 + b));
        expect_now("R6 writes without sync hold outputs");
        do_sync("R2 R7 long frequency transfer", 0, 0, 0);

        // R3: phase bytes.
        wr('h0122, 8'h34); wr('h0123, 8'h12); wr('h0125, 8'h9C);
        expect_now("R6 phase staged not applied");
        do_sync("R3 phase transfer", 0, 0, 0);

        // R4: short view onto osc2 after a full long fill.
        for (int b = 0; b < 8; b++) wr('h0110 + b, 8'(8'h50 + b));
        for (int b = 0; b < 4; b++) wr('h0130 + b, 8'(8'hC0 + b));
        do_sync("R4 short view keeps lower half", 0, 0, 0);

        // R5: long write to an aliased byte, then short write to another.
        wr('h0117, 8'h77);
        wr('h0134, 8'hEE);
        wr('h0104, 8'h44);
        do_sync("R5 shared upper storage", 0, 0, 0);

        // R8: mask with upper nibble set.
        wr('h00FF, 8'hA5);
        do_sync("R8 mask low bits only", 0, 0, 0);
        wr('h00FF, 8'hF2);
        do_sync("R8 second mask", 0, 0, 0);

        // R10: unmapped and neighbouring addresses.
        wr('h00FE, 8'h99); wr('h0138, 8'h99); wr('h0000, 8'h99);
        wr('h3FFF, 8'h99); wr('h01FF, 8'h99); wr('h20FF, 8'h99);
        do_sync("R10 unmapped writes ignored", 0, 0, 0);

        // R11: write in the sync cycle goes to the following sync.
        do_sync("R11 same-cycle write excluded", 1, 'h0108, 8'h5A);
        do_sync("R11 same-cycle write next sync", 0, 0, 0);

        // R9: bypass; transfer still happens (R7).
        @(negedge clk);
        fast_sel = 0;
        #1;
        expect_now("R9 bypass passes normal inputs");
        wr('h0120, 8'hCD);
        do_sync("R9 R7 no pulse in bypass", 0, 0, 0);
        norm_freq = {4{64'h0123_4567_89AB_CDEF}};
        norm_phase = 64'hFEDC_BA98_7654_3210;
        #1;
        expect_now("R9 bypass follows new inputs");
        @(negedge clk);
        fast_sel = 1;
        #1;
        expect_now("R7 transfer in bypass now visible");

        // Reset again mid-run restores defaults (R1).
        @(negedge clk);
        rst_n = 0;
        @(negedge clk);
        rst_n = 1;
        model_reset();
        #1;
        expect_now("R1 reset clears bank");
        do_sync("R1 mask back to all set", 0, 0, 0);

        repeat (2) @(negedge clk);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule